// File: doc/BRIEF.md
# DSP Frame-Sync Converter Link

This block is the serial front end of a successive-approximation converter when the converter is wired to a DSP serial port. Serial clock, chip select and frame sync are inputs sampled by a faster system clock. The link mode is chosen when chip select falls. If the incoming frame sync is low at that moment, the block enters DSP mode. Chip select may then stay low, and every incoming frame-sync pulse starts one command-and-conversion frame.

In DSP mode, command bits are taken on falling serial-clock edges and events fire on rising edges. Three strobes go to the converter core: a channel select, an acquisition window and a sample strobe. The core hands back its result as a parallel word. The block then announces the result with its own one-clock frame-sync pulse and shifts the word out MSB first. Two framings are supported. The 8-bit framing runs 24 serial clocks per frame. The 16-bit framing stretches acquisition by eight clocks and runs 32 clocks per frame.

Top module: `fsx_dsp_link`

## Requirements
- R1: A falling edge on `cs_n` with `fsync_in` low enters DSP mode (`dsp_mode`=1, `sdo_oe`=1, `sdo`=0). A falling edge on `cs_n` with `fsync_in` high leaves the block inactive: no strobes, and `sdo_oe` stays 0 whatever the frame-sync and clock activity.
- R2: Clock n of a frame means the n-th rising edge of `sclk` after `fsync_in` falls, followed by the n-th falling edge. Command bits are sampled from `sdi` on falling edges, MSB first. `cfg_word` takes the first 8 bits on falling edge 8 (8-bit framing) or falling edge 16 (16-bit framing). Bits 9..16 are ignored.
- R3: On falling edge 3, `chan_sel` becomes the first three command bits (`cfg_word[7:5]`) and `chan_strobe` pulses once. `acquire` goes high at the same edge.
- R4: On rising edge 7 (8-bit framing) or 15 (16-bit framing), `sample_strobe` pulses exactly once per frame and `acquire` falls. `sample_data` is captured at that edge only.
- R5: `fsync_out` goes high on rising edge 8 (8-bit) or 16 (16-bit) and stays high for exactly one serial clock period, until the next rising edge.
- R6: From the next rising edge (9 or 17), `sdo` presents one bit per rising edge, MSB first. The 16 bits are the 14-bit sample followed by two zero bits, so the frame ends at clock 24 or 32.
- R7: `sdo` is 0 after a new frame starts and on every rising edge after the word, until the next frame.
- R8: An incoming frame sync during a frame aborts that frame: `fsync_out` and `acquire` clear. The new frame's timing counts from the new frame-sync falling edge.
- R9: A rising edge on `cs_n` aborts any frame and shuts the link down (`dsp_mode`=0, `sdo_oe`=0, no further strobes) until the next falling edge of `cs_n`.
- R10: The scan field (`cfg_word[4:3]`) has no effect: every frame has one channel strobe and one sample strobe at the fixed positions.
- R11: After reset, `dsp_mode`, `sdo_oe`, `sdo`, `fsync_out`, `acquire` and the strobes are 0, and `chan_sel` and `cfg_word` are 0.
- R12: With `cs_n` held low, any number of consecutive frames run correctly, each started by its own frame-sync pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial lines |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| fsync_in | input | 1 | Incoming frame sync from the DSP |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial command data |
| wide_sel | input | 1 | 1 selects 16-bit framing, sampled at frame start |
| sample_data | input | 14 | Parallel result from the converter core |
| sdo | output | 1 | Serial result data |
| sdo_oe | output | 1 | Output enable for `sdo` (0 = high impedance) |
| fsync_out | output | 1 | Outgoing frame sync, one serial clock wide |
| chan_sel | output | 3 | Channel selected for conversion |
| chan_strobe | output | 1 | One-cycle pulse when the channel is selected |
| acquire | output | 1 | Acquisition window to the core |
| sample_strobe | output | 1 | One-cycle pulse at the sampling instant |
| cfg_word | output | 8 | Last complete command word |
| dsp_mode | output | 1 | DSP link mode active |

## Verification
The bench builds the block with its default parameters: an 8-bit command, 8 extra acquisition clocks in wide framing, a 14-bit sample and a 3-bit channel field. With these values, all eight channels can be swept in both framings, with the scan bits varying across the sweep. At every rising edge, the bench compares `fsync_out` and `sdo` against positions it computes from the framing. `sample_data` holds the true sample only during the sampling clock, so a capture one edge off shows up as a wrong word. The sweep is followed by an abort by a new frame sync after the outgoing pulse, a chip-select abort in mid-acquisition, and an entry with the frame sync high.

// File: rtl/fsx_pkg.sv
`timescale 1ns/1ps
package fsx_pkg;

  typedef enum logic [1:0] {
    LINK_OFF   = 2'd0,
    LINK_OTHER = 2'd1,
    LINK_DSP   = 2'd2
  } link_t;

  // rising-edge index at which the core samples
  function automatic int unsigned fsx_sample_pos(input logic wide,
                                                 input int unsigned cmd_w,
                                                 input int unsigned ext_w);
    return wide ? (cmd_w + ext_w - 1) : (cmd_w - 1);
  endfunction

  // rising-edge index of the outgoing frame-sync pulse
  function automatic int unsigned fsx_sync_pos(input logic wide,
                                               input int unsigned cmd_w,
                                               input int unsigned ext_w);
    return fsx_sample_pos(wide, cmd_w, ext_w) + 1;
  endfunction

  // first rising edge that drives a result bit
  function automatic int unsigned fsx_first_data(input logic wide,
                                                 input int unsigned cmd_w,
                                                 input int unsigned ext_w);
    return fsx_sync_pos(wide, cmd_w, ext_w) + 1;
  endfunction

  // falling edge that closes the command field
  function automatic int unsigned fsx_cmd_last(input logic wide,
                                               input int unsigned cmd_w,
                                               input int unsigned ext_w);
    return wide ? (cmd_w + ext_w) : cmd_w;
  endfunction

endpackage

// File: rtl/fsx_edge_sense.sv
`timescale 1ns/1ps
module fsx_edge_sense #(
  parameter int unsigned N          = 3,
  parameter logic [N-1:0] IDLE_LVL  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise_ev,
  output logic [N-1:0] fall_ev
);

  logic [N-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= IDLE_LVL;
    else        prev_q <= lvl;
  end

  for (genvar i = 0; i < N; i++) begin : g_edge
    assign rise_ev[i] = lvl[i] & ~prev_q[i];
    assign fall_ev[i] = ~lvl[i] & prev_q[i];
  end

endmodule

// File: rtl/fsx_frame_seq.sv
`timescale 1ns/1ps
module fsx_frame_seq
  import fsx_pkg::*;
#(
  parameter int unsigned CMD_W = 8,
  parameter int unsigned EXT_W = 8,
  parameter int unsigned CH_W  = 3,
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             cs_fall,
  input  logic             cs_rise,
  input  logic             fs_lvl,
  input  logic             fs_fall,
  input  logic             fs_rise,
  input  logic             sclk_rise,
  input  logic             sclk_fall,
  input  logic             wide_in,
  output logic             link_dsp,
  output logic             frame_start,
  output logic             fall_tick,
  output logic [CNT_W-1:0] fall_idx,
  output logic             chan_ev,
  output logic             cmd_ev,
  output logic             samp_ev,
  output logic             shift_go,
  output logic             chan_strobe,
  output logic             sample_strobe,
  output logic             fsync_out,
  output logic             acquire
);

  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'((1 << CNT_W) - 2);
  localparam logic [CNT_W-1:0] CH_POS  = CNT_W'(CH_W);

  link_t            link_q;
  logic             frame_on;
  logic             frame_kill;
  logic             wide_q;
  logic             rise_tick;
  logic             sync_ev;
  logic [CNT_W-1:0] rcnt, fcnt;
  logic [CNT_W-1:0] rise_idx;
  logic [CNT_W-1:0] samp_pos, sync_pos, first_pos, cmd_pos;

  // link mode decided by frame-sync level at chip-select fall
  always_ff @(posedge clk) begin
    if (!rst_n)       link_q <= LINK_OFF;
    else if (cs_n)    link_q <= LINK_OFF;
    else if (cs_fall) link_q <= fs_lvl ? LINK_OTHER : LINK_DSP;
  end

  assign link_dsp    = (link_q == LINK_DSP);
  assign frame_start = link_dsp & ~cs_n & fs_fall;
  assign frame_kill  = cs_n | fs_lvl | ~link_dsp;

  always_ff @(posedge clk) begin
    if (!rst_n)           frame_on <= 1'b0;
    else if (frame_start) frame_on <= 1'b1;
    else if (frame_kill)  frame_on <= 1'b0;
  end

  // edge counters, saturating
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rcnt   <= '0;
      fcnt   <= '0;
      wide_q <= 1'b0;
    end else if (frame_start) begin
      rcnt   <= '0;
      fcnt   <= '0;
      wide_q <= wide_in;
    end else begin
      if (rise_tick && rcnt != CNT_TOP) rcnt <= rcnt + 1'b1;
      if (fall_tick && fcnt != CNT_TOP) fcnt <= fcnt + 1'b1;
    end
  end

  assign rise_tick = frame_on & ~frame_kill & sclk_rise;
  assign fall_tick = frame_on & ~frame_kill & sclk_fall;
  assign rise_idx  = rcnt + 1'b1;
  assign fall_idx  = fcnt + 1'b1;

  assign samp_pos  = CNT_W'(fsx_sample_pos(wide_q, CMD_W, EXT_W));
  assign sync_pos  = CNT_W'(fsx_sync_pos(wide_q, CMD_W, EXT_W));
  assign first_pos = CNT_W'(fsx_first_data(wide_q, CMD_W, EXT_W));
  assign cmd_pos   = CNT_W'(fsx_cmd_last(wide_q, CMD_W, EXT_W));

  assign chan_ev  = fall_tick & (fall_idx == CH_POS);
  assign cmd_ev   = fall_tick & (fall_idx == cmd_pos);
  assign samp_ev  = rise_tick & (rise_idx == samp_pos);
  assign sync_ev  = rise_tick & (rise_idx == sync_pos);
  assign shift_go = rise_tick & (rise_idx >= first_pos);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chan_strobe   <= 1'b0;
      sample_strobe <= 1'b0;
    end else begin
      chan_strobe   <= chan_ev;
      sample_strobe <= samp_ev;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                          acquire <= 1'b0;
    else if (frame_kill || frame_start)  acquire <= 1'b0;
    else if (chan_ev)                    acquire <= 1'b1;
    else if (samp_ev)                    acquire <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                          fsync_out <= 1'b0;
    else if (frame_kill || frame_start)  fsync_out <= 1'b0;
    else if (sync_ev)                    fsync_out <= 1'b1;
    else if (rise_tick)                  fsync_out <= 1'b0;
  end

  // R5
  fsout_one_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fsync_out && rise_tick) |=> !fsync_out);

  // R5
  fsout_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fsync_out) |-> $past(sclk_rise));

  // R4
  sample_in_acq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_strobe |-> $past(acquire));

  // R8
  fs_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fs_rise |=> (!fsync_out && !acquire));

  // R9
  cs_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || cs_rise) |=> (!fsync_out && !acquire && !link_dsp));

endmodule

// File: rtl/fsx_cmd_capture.sv
`timescale 1ns/1ps
module fsx_cmd_capture #(
  parameter int unsigned CMD_W = 8,
  parameter int unsigned CH_W  = 3,
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sdi,
  input  logic             frame_start,
  input  logic             fall_tick,
  input  logic [CNT_W-1:0] fall_idx,
  input  logic             chan_ev,
  input  logic             cmd_ev,
  output logic [CH_W-1:0]  chan_sel,
  output logic [CMD_W-1:0] cfg_word
);

  localparam logic [CNT_W-1:0] CMD_LAST = CNT_W'(CMD_W);

  logic [CMD_W-1:0] sr_q, sr_next;
  logic             shift_en;

  // only the first CMD_W falling edges carry command bits
  assign shift_en = fall_tick & (fall_idx <= CMD_LAST);
  assign sr_next  = shift_en ? {sr_q[CMD_W-2:0], sdi} : sr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)           sr_q <= '0;
    else if (frame_start) sr_q <= '0;
    else                  sr_q <= sr_next;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chan_sel <= '0;
      cfg_word <= '0;
    end else begin
      if (chan_ev) chan_sel <= sr_next[CH_W-1:0];
      if (cmd_ev)  cfg_word <= sr_next;
    end
  end

  // R3
  chan_cfg_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ev |=> (cfg_word[CMD_W-1 -: CH_W] == chan_sel));

endmodule

// File: rtl/fsx_result_out.sv
`timescale 1ns/1ps
module fsx_result_out #(
  parameter int unsigned RES_W = 14,
  parameter int unsigned OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             link_dsp,
  input  logic             frame_start,
  input  logic             samp_ev,
  input  logic             shift_go,
  input  logic [RES_W-1:0] sample_data,
  output logic             sdo
);

  localparam int unsigned PAD_W = (OUT_W > RES_W) ? (OUT_W - RES_W) : 0;

  logic [OUT_W-1:0] load_word;
  logic [OUT_W-1:0] sr_q;

  if (PAD_W > 0) begin : g_pad
    assign load_word = {sample_data, {PAD_W{1'b0}}};
  end else begin : g_trunc
    assign load_word = sample_data[RES_W-1 -: OUT_W];
  end

  // zeros fill behind the word, so trailing clocks shift out zeros
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q <= '0;
      sdo  <= 1'b0;
    end else if (!link_dsp || frame_start) begin
      sr_q <= '0;
      sdo  <= 1'b0;
    end else if (samp_ev) begin
      sr_q <= load_word;
    end else if (shift_go) begin
      sdo  <= sr_q[OUT_W-1];
      sr_q <= {sr_q[OUT_W-2:0], 1'b0};
    end
  end

  // R6
  sdo_moves_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo) |-> $past(shift_go || frame_start || !link_dsp));

endmodule

// File: rtl/fsx_dsp_link.sv
`timescale 1ns/1ps
module fsx_dsp_link #(
  parameter int unsigned CMD_W = 8,
  parameter int unsigned EXT_W = 8,
  parameter int unsigned CH_W  = 3,
  parameter int unsigned RES_W = 14,
  parameter int unsigned OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             fsync_in,
  input  logic             sclk,
  input  logic             sdi,
  input  logic             wide_sel,
  input  logic [RES_W-1:0] sample_data,
  output logic             sdo,
  output logic             sdo_oe,
  output logic             fsync_out,
  output logic [CH_W-1:0]  chan_sel,
  output logic             chan_strobe,
  output logic             acquire,
  output logic             sample_strobe,
  output logic [CMD_W-1:0] cfg_word,
  output logic             dsp_mode
);

  localparam int unsigned CNT_W = $clog2(CMD_W + EXT_W + OUT_W + 2) + 1;

  // bit 0 serial clock, bit 1 chip select, bit 2 frame sync
  logic [2:0]       lvl, rise_ev, fall_ev;
  logic             link_dsp, frame_start, fall_tick;
  logic [CNT_W-1:0] fall_idx;
  logic             chan_ev, cmd_ev, samp_ev, shift_go;

  assign lvl = {fsync_in, cs_n, sclk};

  fsx_edge_sense #(.N(3), .IDLE_LVL(3'b010)) edge_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .lvl     (lvl),
    .rise_ev (rise_ev),
    .fall_ev (fall_ev)
  );

  fsx_frame_seq #(.CMD_W(CMD_W), .EXT_W(EXT_W), .CH_W(CH_W), .CNT_W(CNT_W)) seq_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cs_n          (cs_n),
    .cs_fall       (fall_ev[1]),
    .cs_rise       (rise_ev[1]),
    .fs_lvl        (fsync_in),
    .fs_fall       (fall_ev[2]),
    .fs_rise       (rise_ev[2]),
    .sclk_rise     (rise_ev[0]),
    .sclk_fall     (fall_ev[0]),
    .wide_in       (wide_sel),
    .link_dsp      (link_dsp),
    .frame_start   (frame_start),
    .fall_tick     (fall_tick),
    .fall_idx      (fall_idx),
    .chan_ev       (chan_ev),
    .cmd_ev        (cmd_ev),
    .samp_ev       (samp_ev),
    .shift_go      (shift_go),
    .chan_strobe   (chan_strobe),
    .sample_strobe (sample_strobe),
    .fsync_out     (fsync_out),
    .acquire       (acquire)
  );

  fsx_cmd_capture #(.CMD_W(CMD_W), .CH_W(CH_W), .CNT_W(CNT_W)) cmd_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .sdi         (sdi),
    .frame_start (frame_start),
    .fall_tick   (fall_tick),
    .fall_idx    (fall_idx),
    .chan_ev     (chan_ev),
    .cmd_ev      (cmd_ev),
    .chan_sel    (chan_sel),
    .cfg_word    (cfg_word)
  );

  fsx_result_out #(.RES_W(RES_W), .OUT_W(OUT_W)) res_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .link_dsp    (link_dsp),
    .frame_start (frame_start),
    .samp_ev     (samp_ev),
    .shift_go    (shift_go),
    .sample_data (sample_data),
    .sdo         (sdo)
  );

  assign sdo_oe   = link_dsp & ~cs_n;
  assign dsp_mode = link_dsp;

  // R1
  oe_off_when_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sdo_oe);

  // R10
  strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({chan_strobe, sample_strobe}));

endmodule

// File: tb/fsx_dsp_link_tb_top.sv
`timescale 1ns/1ps
module fsx_dsp_link_tb_top;

  localparam int H = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_n, fsync_in, sclk, sdi, wide_sel;
  logic [13:0] sample_data;
  logic        sdo, sdo_oe, fsync_out, chan_strobe, acquire, sample_strobe, dsp_mode;
  logic [2:0]  chan_sel;
  logic [7:0]  cfg_word;

  int checks = 0;
  int fails  = 0;
  int rise_n = 0;
  int fall_n = 0;
  int samp_cnt = 0, samp_at = 0, chan_cnt = 0, chan_at = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fsx_dsp_link dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .fsync_in(fsync_in), .sclk(sclk),
    .sdi(sdi), .wide_sel(wide_sel), .sample_data(sample_data), .sdo(sdo),
    .sdo_oe(sdo_oe), .fsync_out(fsync_out), .chan_sel(chan_sel),
    .chan_strobe(chan_strobe), .acquire(acquire), .sample_strobe(sample_strobe),
    .cfg_word(cfg_word), .dsp_mode(dsp_mode)
  );

  // strobe monitor
  always @(posedge clk) begin
    if (sample_strobe) begin samp_cnt++; samp_at = rise_n; end
    if (chan_strobe)   begin chan_cnt++; chan_at = fall_n; end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic edge_rise(input logic b);
    @(negedge clk);
    rise_n++;
    sclk = 1'b1;
    sdi  = b;
    settle(H - 1);
  endtask

  task automatic edge_fall();
    @(negedge clk);
    fall_n++;
    sclk = 1'b0;
    settle(H - 1);
  endtask

  task automatic clear_counts();
    rise_n = 0; fall_n = 0;
    samp_cnt = 0; samp_at = 0; chan_cnt = 0; chan_at = 0;
  endtask

  task automatic pulse_fs();
    @(negedge clk) fsync_in = 1'b1;
    settle(H);
    fsync_in = 1'b0;
    settle(H);
  endtask

  task automatic run_frame(input bit wide, input logic [7:0] cmd,
                           input logic [7:0] ext, input logic [13:0] smp);
    int f_pos, s_pos, nclk;
    logic [15:0] word;
    f_pos = wide ? 16 : 8;
    s_pos = f_pos - 1;
    nclk  = f_pos + 16 + 3;
    word  = {smp, 2'b00};
    wide_sel = wide;
    clear_counts();
    pulse_fs();
    chk(fsync_out == 1'b0, "R8 fsync_out after new frame", int'(fsync_out), 0);
    chk(sdo == 1'b0, "R7 sdo at frame start", int'(sdo), 0);
    for (int n = 1; n <= nclk; n++) begin
      logic b;
      logic exp_sdo;
      if (n <= 8)       b = cmd[8 - n];
      else if (n <= 16) b = ext[16 - n];
      else              b = 1'b0;
      sample_data = (n == s_pos) ? smp : ~smp;
      edge_rise(b);
      chk(fsync_out == (n == f_pos), "R5 fsync_out", int'(fsync_out), int'(n == f_pos));
      exp_sdo = (n > f_pos && n <= f_pos + 16) ? word[16 - (n - f_pos)] : 1'b0;
      if (n > f_pos + 16) chk(sdo == exp_sdo, "R7 trailing zero", int'(sdo), int'(exp_sdo));
      else                chk(sdo == exp_sdo, "R6 sdo bit", int'(sdo), int'(exp_sdo));
      edge_fall();
      if (n == 3) begin
        chk(chan_sel == cmd[7:5], "R3 chan_sel", int'(chan_sel), int'(cmd[7:5]));
        chk(acquire == 1'b1, "R3 acquire high", int'(acquire), 1);
      end
    end
    chk(cfg_word == cmd, "R2 cfg_word", int'(cfg_word), int'(cmd));
    chk(chan_cnt == 1, "R10 one channel strobe", chan_cnt, 1);
    chk(chan_at == 3, "R3 channel strobe position", chan_at, 3);
    chk(samp_cnt == 1, "R10 one sample strobe", samp_cnt, 1);
    chk(samp_at == s_pos, "R4 sample strobe position", samp_at, s_pos);
    chk(acquire == 1'b0, "R4 acquire ended", int'(acquire), 0);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; fsync_in = 1'b0; sclk = 1'b0; sdi = 1'b0;
    wide_sel = 1'b0; sample_data = '0;
    settle(5);
    rst_n = 1'b1;
    settle(3);

    // R11 reset state
    chk(dsp_mode == 0, "R11 dsp_mode", int'(dsp_mode), 0);
    chk(sdo_oe == 0, "R11 sdo_oe", int'(sdo_oe), 0);
    chk(sdo == 0, "R11 sdo", int'(sdo), 0);
    chk(fsync_out == 0, "R11 fsync_out", int'(fsync_out), 0);
    chk(acquire == 0, "R11 acquire", int'(acquire), 0);
    chk(chan_sel == 0 && cfg_word == 0, "R11 chan/cfg", int'(cfg_word), 0);

    // R1 entry with frame sync high: not DSP mode
    @(negedge clk) fsync_in = 1'b1;
    settle(H);
    cs_n = 1'b0;
    settle(H);
    chk(dsp_mode == 0, "R1 non-dsp entry mode", int'(dsp_mode), 0);
    chk(sdo_oe == 0, "R1 non-dsp entry oe", int'(sdo_oe), 0);
    fsync_in = 1'b0;
    settle(H);
    clear_counts();
    for (int n = 0; n < 30; n++) begin edge_rise(1'b1); edge_fall(); end
    chk(samp_cnt == 0 && chan_cnt == 0, "R1 inactive strobes", samp_cnt + chan_cnt, 0);
    chk(sdo_oe == 0, "R1 inactive oe", int'(sdo_oe), 0);
    cs_n = 1'b1;
    settle(H);

    // R1 proper DSP entry
    cs_n = 1'b0;
    settle(H);
    chk(dsp_mode == 1, "R1 dsp entry mode", int'(dsp_mode), 1);
    chk(sdo_oe == 1, "R1 dsp entry oe", int'(sdo_oe), 1);
    chk(sdo == 0, "R1 dsp entry sdo", int'(sdo), 0);

    // R12 consecutive frames, both framings, all channels; R10 scan bits vary
    for (int w = 0; w < 2; w++) begin
      for (int ch = 0; ch < 8; ch++) begin
        logic [7:0]  cmd;
        logic [13:0] smp;
        cmd = {3'(ch), 2'(ch + w), 3'(5 + ch)};
        if (ch == 7)      smp = 14'h3FFF;
        else if (ch == 0) smp = 14'(w * 16'h2AAA);
        else              smp = 14'((ch * 2617 + w * 4099 + 3) % 16384);
        run_frame(w[0], cmd, 8'hA5 ^ 8'(ch), smp);
      end
    end

    // R8 abort by a new frame sync after the outgoing pulse
    wide_sel = 1'b0;
    clear_counts();
    pulse_fs();
    for (int n = 1; n <= 8; n++) begin
      sample_data = 14'h1234;
      edge_rise(n <= 3 ? 1'b1 : 1'b0);
      edge_fall();
    end
    chk(fsync_out == 1, "R5 pulse before abort", int'(fsync_out), 1);
    run_frame(1'b0, 8'b010_11_001, 8'h00, 14'h0ABC);

    // R9 chip select abort mid-acquisition
    clear_counts();
    pulse_fs();
    for (int n = 1; n <= 4; n++) begin edge_rise(1'b1); edge_fall(); end
    chk(acquire == 1, "R9 acquiring before abort", int'(acquire), 1);
    @(negedge clk) cs_n = 1'b1;
    settle(H);
    chk(dsp_mode == 0, "R9 mode off", int'(dsp_mode), 0);
    chk(sdo_oe == 0, "R9 oe off", int'(sdo_oe), 0);
    chk(acquire == 0, "R9 acquire off", int'(acquire), 0);
    clear_counts();
    for (int n = 0; n < 20; n++) begin edge_rise(1'b0); edge_fall(); end
    chk(samp_cnt == 0, "R9 no sample strobe", samp_cnt, 0);
    chk(fsync_out == 0, "R9 no fsync_out", int'(fsync_out), 0);
    cs_n = 1'b0;
    settle(H);
    chk(dsp_mode == 1, "R9 re-entry", int'(dsp_mode), 1);
    run_frame(1'b1, 8'b111_00_110, 8'hFF, 14'h2001);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule